// File: doc/BRIEF.md
# Universal Counter Measurement Sequencer

This block sequences the measurements of a multi-mode counter/timer. It watches two event inputs, A and B, and a timebase tick. It counts only falling edges on A and B. A prescaler turns the tick into a slow reference strobe. Two counters do the work: a decade reference counter and a BCD main counter. The reference counter decides when the counting window opens and closes. The main counter accumulates whatever the selected mode routes to it.

A 3-bit function code selects the mode: frequency, period, ratio, time interval, totalize, or timebase self-test. A 2-bit range code picks the window length, 1, 10, 100 or 1000 reference events. When a window closes, the block leaves its busy state and starts a dead time. During the dead time a store pulse loads the main count into the display latches, and a later reset pulse clears the main counter. The next window then arms.

Hold, a synchronous clear and an external gate input change this sequence. The tick divisors and the dead-time lengths are parameters, so a fast simulation can use a scaled timebase.

Top module: `uc_seq`

## Requirements
- R1: Only a high-to-low transition on `in_a_i` or `in_b_i` (a cycle in which the input is 0 after being 1 the cycle before) counts as an event.
- R2: Frequency mode (`func_i` 0, and also 6 and 7) counts A falls over a window of N reference periods, where N = 10^`range_i`. The window opens and closes on a reference strobe.
- R3: Period mode (`func_i` 1) counts timebase ticks from one A fall to the N-th following A fall. The result is N times the A period, measured in ticks.
- R4: Ratio mode (`func_i` 2) counts A falls from one B fall to the N-th following B fall.
- R5: Time-interval mode (`func_i` 3) counts the ticks between each A fall and the next B fall. It sums N such intervals and then stores the total.
- R6: Totalize mode (`func_i` 4) counts A falls continuously, and the latches follow the count one cycle later. While `hold_i` is 1 the latches freeze, but counting goes on.
- R7: The reference strobe fires once every `DIV_HI` ticks. When `mhz1_i` is 1 it fires once every `DIV_LO` ticks instead. Self-test mode (`func_i` 5) counts ticks over a window of N reference periods.
- R8: When a window closes, `meas_o` drops for `DEAD_REFS` reference periods. `store_o` is high for the first `STORE_REFS` of those periods. `rst_o` is high from period `RST_AT` for `RST_REFS` periods.
- R9: Any change of `func_i`, and any change of `range_i` or `ext_en_i` outside totalize, aborts the current window without a store and re-arms at once. In totalize, a range change has no effect.
- R10: Outside totalize, `hold_i` clears the main counter and keeps the block armed without a store. The last result stays displayed, and a new window starts after release.
- R11: With `ext_en_i` at 1, the window opens at the first reference strobe that sees `ext_gate_i` at 1. It closes at the first strobe that sees it at 0.
- R12: `clr_i`, and the asynchronous reset, zero the latches and the overflow flag and re-arm the block.
- R13: A carry out of the top BCD decade sets a sticky overflow flag. The flag is latched to `ovf_o` together with the digits and is cleared by the reset pulse or by an abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase tick strobe |
| in_a_i | input | 1 | Event input A (level) |
| in_b_i | input | 1 | Event input B (level) |
| func_i | input | 3 | Mode code |
| range_i | input | 2 | Range code; the window is 10^code events |
| ext_en_i | input | 1 | Use the external gate in place of the range |
| ext_gate_i | input | 1 | External gate level |
| hold_i | input | 1 | Hold request |
| clr_i | input | 1 | Synchronous clear of the count and the latches |
| mhz1_i | input | 1 | Select the low prescaler divisor |
| disp_o | output | DIGITS*4 | Latched BCD digits, least significant digit in the low nibble |
| ovf_o | output | 1 | Latched overflow |
| meas_o | output | 1 | Measurement in progress (armed or counting) |
| store_o | output | 1 | Store pulse |
| rst_o | output | 1 | Main-counter reset pulse |

## Verification
The assertions assume that the divisor `DIV_LO` is at least 2, so that two reference strobes are never adjacent. They also assume that the mode code stays fixed for the cycle after a hold or clear. The stimulus drives every input at the falling clock edge. It holds a mode until the result is read. It keeps edges on A and B apart in time-interval mode, and it gives A and B periods that divide the window exactly, so that each count is exact.

// File: rtl/uc_pkg.sv
package uc_pkg;
  localparam logic [2:0] FN_FREQ  = 3'd0;
  localparam logic [2:0] FN_PER   = 3'd1;
  localparam logic [2:0] FN_RATIO = 3'd2;
  localparam logic [2:0] FN_TI    = 3'd3;
  localparam logic [2:0] FN_TOT   = 3'd4;
  localparam logic [2:0] FN_OSC   = 3'd5;

  typedef enum logic [1:0] {
    ST_ARM  = 2'd0,
    ST_RUN  = 2'd1,
    ST_DEAD = 2'd2
  } st_e;
endpackage

// File: rtl/uc_prescale.sv
module uc_prescale #(
  parameter int unsigned DIV_HI = 100000,
  parameter int unsigned DIV_LO = 10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic lo_sel_i,
  output logic ref_o
);
  localparam int unsigned CW = $clog2(DIV_HI + 1);
  localparam logic [CW-1:0] LIM_HI = CW'(DIV_HI - 1);
  localparam logic [CW-1:0] LIM_LO = CW'(DIV_LO - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim   = lo_sel_i ? LIM_LO : LIM_HI;
  // >= so a divisor switch mid-count cannot stall
  assign ref_o = tick_i && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= ref_o ? '0 : cnt_q + 1'b1;
  end

  // R7
  ref_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_o |=> !ref_o);
endmodule

// File: rtl/uc_ref_cnt.sv
module uc_ref_cnt #(
  parameter int unsigned RANGES = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_i,
  input  logic                      ev_i,
  input  logic [$clog2(RANGES)-1:0] exp_i,
  output logic                      last_o
);
  localparam int unsigned RW = $clog2(RANGES);

  function automatic int unsigned pow10(input int unsigned e);
    int unsigned v = 1;
    for (int unsigned i = 0; i < e; i++) v = v * 10;
    return v;
  endfunction

  localparam int unsigned MAX_N = pow10(RANGES - 1);
  localparam int unsigned CW    = $clog2(MAX_N + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] tgt;

  always_comb begin
    tgt = '0;
    for (int unsigned r = 0; r < RANGES; r++)
      if (exp_i == RW'(r)) tgt = CW'(pow10(r) - 1);
  end

  assign last_o = ev_i && (cnt_q == tgt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (ev_i)  cnt_q <= last_o ? '0 : cnt_q + 1'b1;
  end

  // R2
  ref_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> (cnt_q == '0));
endmodule

// File: rtl/uc_bcd_cnt.sv
module uc_bcd_cnt #(
  parameter int unsigned DIGITS = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  inc_i,
  output logic [DIGITS*4-1:0]   cnt_o,
  output logic                  ovf_o
);
  logic [DIGITS:0] cy;
  logic            ovf_q;

  assign cy[0] = inc_i;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    logic [3:0] d_q;
    assign cy[g+1]       = cy[g] && (d_q == 4'd9);
    assign cnt_o[g*4+:4] = d_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    d_q <= '0;
      else if (clr_i) d_q <= '0;
      else if (cy[g]) d_q <= (d_q == 4'd9) ? 4'd0 : d_q + 4'd1;
    end

    // R2
    digit_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      d_q <= 4'd9);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            ovf_q <= 1'b0;
    else if (clr_i)         ovf_q <= 1'b0;
    else if (cy[DIGITS])    ovf_q <= 1'b1;
  end

  assign ovf_o = ovf_q;

  // R13
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !clr_i) |=> ovf_q);
endmodule

// File: rtl/uc_seq.sv
module uc_seq
  import uc_pkg::*;
#(
  parameter int unsigned DIGITS     = 8,
  parameter int unsigned RANGES     = 4,
  parameter int unsigned DIV_HI     = 100000,
  parameter int unsigned DIV_LO     = 10000,
  parameter int unsigned DEAD_REFS  = 20,
  parameter int unsigned STORE_REFS = 4,
  parameter int unsigned RST_AT     = 10,
  parameter int unsigned RST_REFS   = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      tick_i,
  input  logic                      in_a_i,
  input  logic                      in_b_i,
  input  logic [2:0]                func_i,
  input  logic [$clog2(RANGES)-1:0] range_i,
  input  logic                      ext_en_i,
  input  logic                      ext_gate_i,
  input  logic                      hold_i,
  input  logic                      clr_i,
  input  logic                      mhz1_i,
  output logic [DIGITS*4-1:0]       disp_o,
  output logic                      ovf_o,
  output logic                      meas_o,
  output logic                      store_o,
  output logic                      rst_o
);
  localparam int unsigned RW = $clog2(RANGES);
  localparam int unsigned NW = DIGITS * 4;
  localparam int unsigned DW = $clog2(DEAD_REFS + 1);
  localparam logic [DW-1:0] D_LAST = DW'(DEAD_REFS - 1);
  localparam logic [DW-1:0] S_END  = DW'(STORE_REFS);
  localparam logic [DW-1:0] R_BEG  = DW'(RST_AT);
  localparam logic [DW-1:0] R_END  = DW'(RST_AT + RST_REFS);

  st_e           st_q, st_d;
  logic [DW-1:0] dcnt_q;
  logic          a_q, b_q, a_fall, b_fall;
  logic [2:0]    func_q;
  logic [RW-1:0] rng_q;
  logic          ext_q;
  logic          ti_on_q, ti_on_d;
  logic          entry_q;
  logic [NW-1:0] disp_q, main_cnt;
  logic          ovf_q, main_ovf;
  logic          ref_tick, ref_last;
  logic          tot, ti, func_chg, rng_chg, abort;
  logic          main_ev, ref_ev, open_ev, close_ev, main_inc, main_clr;

  // event edges
  assign a_fall = a_q && !in_a_i;
  assign b_fall = b_q && !in_b_i;

  assign tot      = (func_i == FN_TOT);
  assign ti       = (func_i == FN_TI);
  assign func_chg = (func_i != func_q);
  assign rng_chg  = !tot && ((range_i != rng_q) || (ext_en_i != ext_q));
  assign abort    = func_chg || rng_chg || clr_i || (hold_i && !tot);

  // routing
  always_comb begin
    unique case (func_i)
      FN_PER:   begin main_ev = tick_i; ref_ev = a_fall;            open_ev = a_fall;   end
      FN_RATIO: begin main_ev = a_fall; ref_ev = b_fall;            open_ev = b_fall;   end
      FN_TI:    begin main_ev = tick_i; ref_ev = b_fall && ti_on_q; open_ev = a_fall;   end
      FN_OSC:   begin main_ev = tick_i; ref_ev = ref_tick;          open_ev = ref_tick; end
      default:  begin main_ev = a_fall; ref_ev = ref_tick;          open_ev = ref_tick; end
    endcase
    if (ext_en_i) open_ev = ref_tick && ext_gate_i;
  end

  assign close_ev = ext_en_i ? (ref_tick && !ext_gate_i) : ref_last;

  always_comb begin
    st_d = st_q;
    if (abort || tot) st_d = ST_ARM;
    else begin
      unique case (st_q)
        ST_ARM:  if (open_ev)                       st_d = ST_RUN;
        ST_RUN:  if (close_ev)                      st_d = ST_DEAD;
        ST_DEAD: if (ref_tick && dcnt_q == D_LAST)  st_d = ST_ARM;
        default:                                    st_d = ST_ARM;
      endcase
    end
  end

  always_comb begin
    ti_on_d = 1'b0;
    if (st_d == ST_RUN && ti && !ext_en_i) begin
      if (st_q == ST_ARM) ti_on_d = 1'b1;
      else                ti_on_d = ti_on_q ? !b_fall : a_fall;
    end
  end

  assign store_o  = (st_q == ST_DEAD) && (dcnt_q < S_END);
  assign rst_o    = (st_q == ST_DEAD) && (dcnt_q >= R_BEG) && (dcnt_q < R_END);
  assign meas_o   = (st_q != ST_DEAD);
  assign main_clr = abort || rst_o;
  assign main_inc = tot ? a_fall
                        : ((st_q == ST_RUN) && main_ev && (!ti || ext_en_i || ti_on_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_ARM;
      dcnt_q  <= '0;
      a_q     <= 1'b0;
      b_q     <= 1'b0;
      func_q  <= FN_FREQ;
      rng_q   <= '0;
      ext_q   <= 1'b0;
      ti_on_q <= 1'b0;
      entry_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      a_q     <= in_a_i;
      b_q     <= in_b_i;
      func_q  <= func_i;
      rng_q   <= range_i;
      ext_q   <= ext_en_i;
      ti_on_q <= ti_on_d;
      entry_q <= (st_q != ST_DEAD) && (st_d == ST_DEAD);
      if (st_q != ST_DEAD) dcnt_q <= '0;
      else if (ref_tick)   dcnt_q <= dcnt_q + 1'b1;
    end
  end

  // display latches
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      disp_q <= '0;
      ovf_q  <= 1'b0;
    end else if (clr_i) begin
      disp_q <= '0;
      ovf_q  <= 1'b0;
    end else if (tot) begin
      if (!hold_i) begin
        disp_q <= main_cnt;
        ovf_q  <= main_ovf;
      end
    end else if (entry_q) begin
      disp_q <= main_cnt;
      ovf_q  <= main_ovf;
    end
  end

  assign disp_o = disp_q;
  assign ovf_o  = ovf_q;

  uc_prescale #(.DIV_HI(DIV_HI), .DIV_LO(DIV_LO)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .lo_sel_i (mhz1_i),
    .ref_o    (ref_tick)
  );

  uc_ref_cnt #(.RANGES(RANGES)) u_ref (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  ((st_q != ST_RUN) || abort),
    .ev_i   ((st_q == ST_RUN) && ref_ev && !ext_en_i),
    .exp_i  (range_i),
    .last_o (ref_last)
  );

  uc_bcd_cnt #(.DIGITS(DIGITS)) u_main (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (main_clr),
    .inc_i  (main_inc),
    .cnt_o  (main_cnt),
    .ovf_o  (main_ovf)
  );

  // R9
  abort_rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (func_i != func_q) |=> (meas_o && !store_o));

  // R12
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (disp_o == '0 && !ovf_o));

  // R10
  hold_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && func_i != FN_TOT) |=> (main_cnt == '0));

  // R8
  close_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(meas_o) |-> store_o);

  // R6
  tot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && func_i == FN_TOT && !clr_i) |=> $stable(disp_o));
endmodule

// File: tb/sim_uc_seq.sv
`timescale 1ns/1ps
module sim_uc_seq;
  localparam int DIG = 4;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1;
  logic in_a, in_b;
  logic [2:0] func = 3'd0;
  logic [1:0] rng = 2'd0;
  logic ext_en = 1'b0, ext_gate = 1'b0, hold = 1'b0, clr = 1'b0, mhz1 = 1'b0;
  logic a_man = 1'b0, b_man = 1'b0;
  wire [DIG*4-1:0] disp;
  wire ovf, meas, store, rsto;
  int n_chk = 0, n_fail = 0, cyc = 0, store_cnt = 0;
  int a_per = 0, b_per = 0, b_off = 0;

  uc_seq #(.DIGITS(DIG), .DIV_HI(10), .DIV_LO(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .in_a_i(in_a), .in_b_i(in_b),
    .func_i(func), .range_i(rng), .ext_en_i(ext_en), .ext_gate_i(ext_gate),
    .hold_i(hold), .clr_i(clr), .mhz1_i(mhz1), .disp_o(disp), .ovf_o(ovf),
    .meas_o(meas), .store_o(store), .rst_o(rsto));

  always #10 clk = ~clk;

  // stimulus generators, driven away from the active edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    in_a = (a_per > 0) ? ((cyc % a_per) < a_per / 2) : a_man;
    in_b = (b_per > 0) ? (((cyc + b_per - b_off) % b_per) < b_per / 2) : b_man;
  end

  always @(posedge store) store_cnt++;

  function automatic int bcd2int(input logic [DIG*4-1:0] v);
    int r = 0;
    for (int i = DIG - 1; i >= 0; i--) r = r * 10 + int'(v[i*4+:4]);
    return r;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] f, input logic [1:0] r, input logic e, input logic m);
    @(negedge clk);
    func = f; rng = r; ext_en = e; mhz1 = m; clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic meas_chk(input string tag, input int exp);
    @(posedge store);
    repeat (2) @(negedge clk);
    chk(tag, bcd2int(disp), exp);
  endtask

  task automatic pulse_a();
    a_man = 1'b1; repeat (2) @(negedge clk);
    a_man = 1'b0; repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n0, nst, nrs, ndd;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk("R12 reset disp", bcd2int(disp), 0);
    chk("R12 reset ovf", int'(ovf), 0);
    chk("R8 reset meas", int'(meas), 1);
    chk("R8 reset store", int'(store), 0);
    rst_n = 1'b1;

    // frequency sweep: W = 10^r * 10 ticks, A falls every p
    for (int p = 5; p <= 10; p += 5)
      for (int r = 0; r < 3; r++) begin
        a_per = p;
        cfg(3'd0, r[1:0], 1'b0, 1'b0);
        meas_chk("R1 R2 freq", (10 ** r) * 10 / p);
      end

    // dead time shape
    a_per = 5;
    cfg(3'd0, 2'd0, 1'b0, 1'b0);
    @(posedge store);
    @(negedge clk);
    nst = 0; nrs = 0; ndd = 0;
    while (!meas && ndd < 1000) begin
      if (store) nst++;
      if (rsto) nrs++;
      ndd++;
      @(negedge clk);
    end
    chk("R8 dead length", ndd, 200);
    chk("R8 store length", nst, 40);
    chk("R8 reset length", nrs, 40);

    // period
    for (int r = 0; r < 4; r++) begin
      a_per = 4;
      cfg(3'd1, r[1:0], 1'b0, 1'b0);
      meas_chk("R3 period p4", 4 * (10 ** r));
    end
    for (int r = 0; r < 3; r++) begin
      a_per = 6;
      cfg(3'd1, r[1:0], 1'b0, 1'b0);
      meas_chk("R3 period p6", 6 * (10 ** r));
    end

    // ratio A/B
    for (int r = 0; r < 3; r++) begin
      a_per = 4; b_per = 20; b_off = 0;
      cfg(3'd2, r[1:0], 1'b0, 1'b0);
      meas_chk("R4 ratio", 5 * (10 ** r));
    end

    // time interval: B falls 6 ticks after A
    for (int r = 0; r < 3; r++) begin
      a_per = 20; b_per = 20; b_off = 6;
      cfg(3'd3, r[1:0], 1'b0, 1'b0);
      meas_chk("R5 interval", 6 * (10 ** r));
    end
    b_per = 0;

    // prescaler divisors via self-test
    cfg(3'd5, 2'd0, 1'b0, 1'b0);
    meas_chk("R7 osc high div", 10);
    cfg(3'd5, 2'd0, 1'b0, 1'b1);
    meas_chk("R7 osc low div", 4);
    a_per = 5;
    cfg(3'd0, 2'd1, 1'b0, 1'b1);
    meas_chk("R7 freq low div", 8);

    // overflow
    cfg(3'd5, 2'd3, 1'b0, 1'b0);
    meas_chk("R13 ovf digits", 0);
    chk("R13 ovf set", int'(ovf), 1);
    @(negedge clk); rng = 2'd0;
    meas_chk("R13 after ovf", 10);
    chk("R13 ovf cleared", int'(ovf), 0);

    // abort on range / function change
    a_per = 5;
    cfg(3'd0, 2'd0, 1'b0, 1'b0);
    meas_chk("R9 pre-abort", 2);
    @(negedge clk); rng = 2'd2;
    n0 = store_cnt;
    repeat (500) @(negedge clk);
    chk("R9 range abort no store", store_cnt, n0);
    chk("R9 range abort disp", bcd2int(disp), 2);
    func = 3'd1; rng = 2'd1;
    @(negedge clk);
    chk("R9 func abort disp", bcd2int(disp), 2);
    meas_chk("R9 new period", 50);

    // hold outside totalize
    a_per = 7;
    cfg(3'd1, 2'd1, 1'b0, 1'b0);
    meas_chk("R10 pre-hold", 70);
    @(negedge clk); hold = 1'b1; a_per = 3;
    n0 = store_cnt;
    repeat (300) @(negedge clk);
    chk("R10 hold no store", store_cnt, n0);
    chk("R10 hold disp", bcd2int(disp), 70);
    chk("R10 hold armed", int'(meas), 1);
    hold = 1'b0;
    meas_chk("R10 after hold", 30);

    // clear input
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    chk("R12 clr disp", bcd2int(disp), 0);
    chk("R12 clr ovf", int'(ovf), 0);

    // totalize
    a_per = 0; a_man = 1'b0;
    cfg(3'd4, 2'd0, 1'b0, 1'b0);
    repeat (7) pulse_a();
    chk("R6 total", bcd2int(disp), 7);
    hold = 1'b1;
    repeat (5) pulse_a();
    rng = 2'd2;
    repeat (3) @(negedge clk);
    chk("R6 R9 total frozen", bcd2int(disp), 7);
    hold = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 R9 total continued", bcd2int(disp), 12);

    // external gate: 100 cycles high covers exactly 10 strobes
    a_per = 5; ext_gate = 1'b0;
    cfg(3'd0, 2'd0, 1'b1, 1'b0);
    repeat (37) @(negedge clk);
    ext_gate = 1'b1;
    repeat (100) @(negedge clk);
    ext_gate = 1'b0;
    meas_chk("R11 ext gate", 20);

    finish_run();
  end
endmodule